// File: doc/BRIEF.md
# I2C Flag and Interrupt Unit

This block keeps the status flags of an I2C controller that works as bus master or as slave, and merges them into a single interrupt request. An external byte shifter tells it, with one-cycle strobes, when the first bit of an address byte or a data byte is leaving the shifter, when a byte has been received, and when the final data bit of an incoming byte is on the bus. Register accesses (data register read, data register write, status register read) clear the flags. The block also compares received address bytes against a programmed 7-bit own address, and can optionally recognise the two all-zero reserved codes.

When a received byte is still unread as the next byte reaches its last data bit, the block asks the shifter to stretch SCL low. This request stays up until the byte is read, so no received data is lost. When the controller is disabled, the interrupt line is handed to a tick from the baud-rate generator.

All flags are registered and change one clock after the strobe that causes them. The interrupt request is a combinational merge of those registers.

Top module: `i2c_irq_status`

## Requirements
- R1: With `ctl_enable`, `ctl_tx_ie` and `txbuf_empty` all 1, `flg_txe` goes to 1 one cycle after an `ev_data_tx` strobe. It also goes to 1 after an `ev_addr_tx` strobe with `addr_tx_first10`=1, and after an `ev_addr_tx` strobe with `addr_tx_last`=1 and `addr_tx_read`=0. If any of the three qualifiers is 0, `flg_txe` does not set.
- R2: A `dr_wr` strobe clears `flg_txe` on the next cycle. It wins over a set event in the same cycle.
- R3: An `ev_addr_tx` strobe does not set `flg_txe` when it is the last address byte of a read (`addr_tx_last`=1, `addr_tx_read`=1). It also does not set it for an address byte that is neither the first 10-bit byte nor the last byte.
- R4: In master mode (`ctl_slave`=0), `ev_rx_byte` sets `flg_rxf` one cycle later. `dr_rd` clears it, but a received byte in the same cycle wins.
- R5: If `ev_rx_lastbit` arrives while `flg_rxf`=1, `scl_hold` goes to 1 on the next cycle. It stays at 1 until the cycle after `flg_rxf` is cleared. `scl_hold` is never 1 while `flg_rxf` is 0.
- R6: In slave mode with `ctl_interactive`=0, received address bytes (`rx_is_addr`=1) do not set `flg_rxf`, and neither do data bytes after a non-matching address. With `ctl_interactive`=1, every received address and data byte sets it.
- R7: In slave mode, a received address byte whose bits 7:1 equal `own_addr` sets `flg_match`. Bit 0 of every received address byte is captured into `flg_read` (1 = read).
- R8: With `ctl_gc_en`=1, address bytes 0x00 and 0x01 also set `flg_match`, with `flg_read` = 0 and 1 respectively. With `ctl_gc_en`=0 they do not match.
- R9: `sr_rd` clears `flg_match`. `flg_read` holds until the next received address byte.
- R10: With `ctl_enable`=1, `irq` is the OR of `flg_txe`, `flg_rxf` and `flg_match`. With `ctl_enable`=0, `irq` equals `brg_tick`, and the flags have no effect on it.
- R11: While `rst_n`=0, all flags and `scl_hold` are 0, and `irq` is 0 unless `ctl_enable`=0 and `brg_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable |
| ctl_slave | input | 1 | 1 = slave mode, 0 = master mode |
| ctl_tx_ie | input | 1 | Transmit interrupt enable |
| ctl_gc_en | input | 1 | Recognise general call and start byte codes |
| ctl_interactive | input | 1 | Flag every received slave byte |
| own_addr | input | ADDR_W | Programmed slave address |
| txbuf_empty | input | 1 | Transmit data register holds no byte |
| ev_addr_tx | input | 1 | First bit of an address byte shifted out |
| addr_tx_first10 | input | 1 | That byte is the first byte of a 10-bit address |
| addr_tx_last | input | 1 | That byte is the final address byte |
| addr_tx_read | input | 1 | Current master transaction is a read |
| ev_data_tx | input | 1 | First bit of a data byte shifted out |
| ev_rx_byte | input | 1 | A complete byte was received |
| rx_is_addr | input | 1 | The received byte is an address byte |
| rx_byte | input | ADDR_W+1 | Received byte value |
| ev_rx_lastbit | input | 1 | Final data bit of an incoming byte is in progress |
| dr_wr | input | 1 | Data register write strobe |
| dr_rd | input | 1 | Data register read strobe |
| sr_rd | input | 1 | Status register read strobe |
| brg_tick | input | 1 | Timer interrupt from the baud-rate generator |
| flg_txe | output | 1 | Transmit empty flag |
| flg_rxf | output | 1 | Receive full flag |
| flg_match | output | 1 | Slave address match flag |
| flg_read | output | 1 | Captured direction bit |
| irq | output | 1 | Combined interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The transmit flag is driven with data strobes and with the four kinds of address strobe: first 10-bit byte, last byte of a write, last byte of a read, and middle byte. This separates the direction-dependent qualification from a plain OR of the events, and each of enable, interrupt enable and buffer-empty is dropped in turn. Received address bytes are tried against the own address, a non-matching address, and the codes 0x00 and 0x01, each with the general-call option off and on. This shows the direction bit telling the two reserved codes apart. The same slave sequence is repeated with and without interactive mode, to expose whether address bytes and filtered data bytes reach the receive flag. A held receive is checked over several cycles before and after the data read, to show that the SCL stretch waits for the read.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  typedef struct packed {
    logic txe;
    logic rxf;
    logic match;
  } i2c_flags_t;

  function automatic logic flags_any(input i2c_flags_t f);
    return f.txe | f.rxf | f.match;
  endfunction

endpackage

// File: rtl/i2c_tx_flag.sv
module i2c_tx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tx_ie,
  input  logic txbuf_empty,
  input  logic ev_addr_tx,
  input  logic addr_first10,
  input  logic addr_last,
  input  logic addr_read,
  input  logic ev_data_tx,
  input  logic dr_wr,
  output logic txe
);

  logic trig;
  logic txe_d;

  always_comb begin
    trig = ev_data_tx
         | (ev_addr_tx & addr_first10)
         | (ev_addr_tx & addr_last & ~addr_read);
    txe_d = txe;
    if (en && tx_ie && txbuf_empty && trig) begin
      txe_d = 1'b1;
    end
    if (dr_wr) begin
      txe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe <= 1'b0;
    end else begin
      txe <= txe_d;
    end
  end

endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  output logic              hit
);

  logic own_hit;
  logic zero_hit;

  always_comb begin
    own_hit  = (rx_addr == own_addr);
    zero_hit = gc_en && (rx_addr == '0);
    hit      = own_hit | zero_hit;
  end

endmodule

// File: rtl/i2c_rx_flags.sv
module i2c_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic slave,
  input  logic interactive,
  input  logic ev_rx_byte,
  input  logic rx_is_addr,
  input  logic rx_dir,
  input  logic addr_hit,
  input  logic ev_rx_lastbit,
  input  logic dr_rd,
  input  logic sr_rd,
  output logic rxf,
  output logic match,
  output logic rd_dir,
  output logic hold
);

  logic addr_ok;
  logic addr_ok_d;
  logic rxf_d;
  logic match_d;
  logic rd_dir_d;
  logic hold_d;
  logic rx_ev;
  logic addr_ev;
  logic rx_set;

  always_comb begin
    rx_ev   = en & ev_rx_byte;
    addr_ev = rx_ev & slave & rx_is_addr;

    if (!slave) begin
      rx_set = rx_ev;
    end else if (interactive) begin
      rx_set = rx_ev;
    end else begin
      rx_set = rx_ev & ~rx_is_addr & addr_ok;
    end

    addr_ok_d = addr_ok;
    rd_dir_d  = rd_dir;
    match_d   = match;
    if (sr_rd) begin
      match_d = 1'b0;
    end
    if (addr_ev) begin
      addr_ok_d = addr_hit;
      rd_dir_d  = rx_dir;
      if (addr_hit) begin
        match_d = 1'b1;
      end
    end

    rxf_d = rxf;
    if (dr_rd) begin
      rxf_d = 1'b0;
    end
    if (rx_set) begin
      rxf_d = 1'b1;
    end

    if (!rxf_d) begin
      hold_d = 1'b0;
    end else begin
      hold_d = hold | (ev_rx_lastbit & rxf);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_ok <= 1'b0;
      rxf     <= 1'b0;
      match   <= 1'b0;
      rd_dir  <= 1'b0;
      hold    <= 1'b0;
    end else begin
      addr_ok <= addr_ok_d;
      rxf     <= rxf_d;
      match   <= match_d;
      rd_dir  <= rd_dir_d;
      hold    <= hold_d;
    end
  end

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_slave,
  input  logic              ctl_tx_ie,
  input  logic              ctl_gc_en,
  input  logic              ctl_interactive,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              txbuf_empty,
  input  logic              ev_addr_tx,
  input  logic              addr_tx_first10,
  input  logic              addr_tx_last,
  input  logic              addr_tx_read,
  input  logic              ev_data_tx,
  input  logic              ev_rx_byte,
  input  logic              rx_is_addr,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic              ev_rx_lastbit,
  input  logic              dr_wr,
  input  logic              dr_rd,
  input  logic              sr_rd,
  input  logic              brg_tick,
  output logic              flg_txe,
  output logic              flg_rxf,
  output logic              flg_match,
  output logic              flg_read,
  output logic              irq,
  output logic              scl_hold
);

  localparam int BYTE_W = ADDR_W + 1;

  logic       addr_hit;
  i2c_flags_t flags;

  i2c_tx_flag u_tx_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (ctl_enable),
    .tx_ie        (ctl_tx_ie),
    .txbuf_empty  (txbuf_empty),
    .ev_addr_tx   (ev_addr_tx),
    .addr_first10 (addr_tx_first10),
    .addr_last    (addr_tx_last),
    .addr_read    (addr_tx_read),
    .ev_data_tx   (ev_data_tx),
    .dr_wr        (dr_wr),
    .txe          (flg_txe)
  );

  i2c_addr_cmp #(.ADDR_W(ADDR_W)) u_addr_cmp (
    .rx_addr  (rx_byte[BYTE_W-1:1]),
    .own_addr (own_addr),
    .gc_en    (ctl_gc_en),
    .hit      (addr_hit)
  );

  i2c_rx_flags u_rx_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (ctl_enable),
    .slave         (ctl_slave),
    .interactive   (ctl_interactive),
    .ev_rx_byte    (ev_rx_byte),
    .rx_is_addr    (rx_is_addr),
    .rx_dir        (rx_byte[0]),
    .addr_hit      (addr_hit),
    .ev_rx_lastbit (ev_rx_lastbit),
    .dr_rd         (dr_rd),
    .sr_rd         (sr_rd),
    .rxf           (flg_rxf),
    .match         (flg_match),
    .rd_dir        (flg_read),
    .hold          (scl_hold)
  );

  always_comb begin
    flags.txe   = flg_txe;
    flags.rxf   = flg_rxf;
    flags.match = flg_match;
    if (ctl_enable) begin
      irq = flags_any(flags);
    end else begin
      irq = brg_tick;
    end
  end

endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_enable,
  input logic ctl_slave,
  input logic ctl_tx_ie,
  input logic ev_rx_byte,
  input logic ev_rx_lastbit,
  input logic dr_wr,
  input logic dr_rd,
  input logic sr_rd,
  input logic flg_txe,
  input logic flg_rxf,
  input logic flg_match,
  input logic irq,
  input logic scl_hold
);

  AST_TXE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_txe) |-> $past(ctl_tx_ie)); // R1

  AST_TXE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> !flg_txe); // R2

  AST_RXF_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd && !ev_rx_byte) |=> !flg_rxf); // R4

  AST_HOLD_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> flg_rxf); // R5

  AST_HOLD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_rxf && ev_rx_lastbit && !dr_rd) |=> scl_hold); // R5

  AST_MATCH_IN_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_match) |-> $past(ctl_slave)); // R7

  AST_MATCH_SR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd && !ev_rx_byte) |=> !flg_match); // R9

  AST_IRQ_FROM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && (flg_txe || flg_rxf || flg_match)) |-> irq); // R10

endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_enable    (ctl_enable),
  .ctl_slave     (ctl_slave),
  .ctl_tx_ie     (ctl_tx_ie),
  .ev_rx_byte    (ev_rx_byte),
  .ev_rx_lastbit (ev_rx_lastbit),
  .dr_wr         (dr_wr),
  .dr_rd         (dr_rd),
  .sr_rd         (sr_rd),
  .flg_txe       (flg_txe),
  .flg_rxf       (flg_rxf),
  .flg_match     (flg_match),
  .irq           (irq),
  .scl_hold      (scl_hold)
);

// File: tb/test_i2c_irq_status.sv
`timescale 1ns/1ps
module test_i2c_irq_status;

  logic       clk;
  logic       rst_n;
  logic       ctl_enable, ctl_slave, ctl_tx_ie, ctl_gc_en, ctl_interactive;
  logic [6:0] own_addr;
  logic       txbuf_empty;
  logic       ev_addr_tx, addr_tx_first10, addr_tx_last, addr_tx_read, ev_data_tx;
  logic       ev_rx_byte, rx_is_addr, ev_rx_lastbit;
  logic [7:0] rx_byte;
  logic       dr_wr, dr_rd, sr_rd, brg_tick;
  logic       flg_txe, flg_rxf, flg_match, flg_read, irq, scl_hold;

  int n_chk;
  int n_err;

  i2c_irq_status i_i2c_irq_status (
    .clk(clk), .rst_n(rst_n),
    .ctl_enable(ctl_enable), .ctl_slave(ctl_slave), .ctl_tx_ie(ctl_tx_ie),
    .ctl_gc_en(ctl_gc_en), .ctl_interactive(ctl_interactive), .own_addr(own_addr),
    .txbuf_empty(txbuf_empty), .ev_addr_tx(ev_addr_tx), .addr_tx_first10(addr_tx_first10),
    .addr_tx_last(addr_tx_last), .addr_tx_read(addr_tx_read), .ev_data_tx(ev_data_tx),
    .ev_rx_byte(ev_rx_byte), .rx_is_addr(rx_is_addr), .rx_byte(rx_byte),
    .ev_rx_lastbit(ev_rx_lastbit), .dr_wr(dr_wr), .dr_rd(dr_rd), .sr_rd(sr_rd),
    .brg_tick(brg_tick), .flg_txe(flg_txe), .flg_rxf(flg_rxf), .flg_match(flg_match),
    .flg_read(flg_read), .irq(irq), .scl_hold(scl_hold)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ev_addr_tx = 0; addr_tx_first10 = 0; addr_tx_last = 0; addr_tx_read = 0;
    ev_data_tx = 0; ev_rx_byte = 0; rx_is_addr = 0; rx_byte = 8'h00;
    ev_rx_lastbit = 0; dr_wr = 0; dr_rd = 0; sr_rd = 0;
  endtask

  // one strobe cycle: inputs set before the call, result visible after the edge
  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic rx(input logic is_addr, input logic [7:0] b);
    ev_rx_byte = 1; rx_is_addr = is_addr; rx_byte = b;
    cyc();
  endtask

  task automatic t_reset();
    rst_n = 0; ctl_enable = 1; ctl_slave = 0; ctl_tx_ie = 1; ctl_gc_en = 0;
    ctl_interactive = 0; own_addr = 7'h2A; txbuf_empty = 1; brg_tick = 0;
    idle();
    ev_data_tx = 1; ev_rx_byte = 1;
    repeat (3) @(negedge clk);
    chk("R11 txe in reset", flg_txe, 0);
    chk("R11 rxf in reset", flg_rxf, 0);
    chk("R11 match in reset", flg_match, 0);
    chk("R11 hold in reset", scl_hold, 0);
    chk("R11 irq in reset", irq, 0);
    idle();
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_txe();
    ev_data_tx = 1; cyc();
    chk("R1 data byte sets txe", flg_txe, 1);
    chk("R10 irq from txe", irq, 1);
    dr_wr = 1; cyc();
    chk("R2 write clears txe", flg_txe, 0);
    ev_addr_tx = 1; addr_tx_last = 1; addr_tx_read = 1; cyc();
    chk("R3 last addr of read", flg_txe, 0);
    ev_addr_tx = 1; cyc();
    chk("R3 middle addr byte", flg_txe, 0);
    ev_addr_tx = 1; addr_tx_last = 1; addr_tx_read = 0; cyc();
    chk("R1 last addr of write", flg_txe, 1);
    dr_wr = 1; cyc();
    ev_addr_tx = 1; addr_tx_first10 = 1; addr_tx_read = 1; cyc();
    chk("R1 first 10-bit byte", flg_txe, 1);
    dr_wr = 1; ev_data_tx = 1; cyc();
    chk("R2 write wins over set", flg_txe, 0);
    ctl_tx_ie = 0; ev_data_tx = 1; cyc();
    chk("R1 ie off", flg_txe, 0);
    ctl_tx_ie = 1; txbuf_empty = 0; ev_data_tx = 1; cyc();
    chk("R1 buffer full", flg_txe, 0);
    txbuf_empty = 1; ctl_enable = 0; ev_data_tx = 1; cyc();
    chk("R1 disabled", flg_txe, 0);
    ctl_enable = 1; ctl_tx_ie = 0;
  endtask

  task automatic t_master_rx();
    rx(0, 8'hA5);
    chk("R4 master byte sets rxf", flg_rxf, 1);
    dr_rd = 1; ev_rx_byte = 1; cyc();
    chk("R4 new byte wins over read", flg_rxf, 1);
    ev_rx_lastbit = 1; cyc();
    chk("R5 hold raised", scl_hold, 1);
    repeat (3) @(negedge clk);
    chk("R5 hold kept", scl_hold, 1);
    dr_rd = 1; cyc();
    chk("R4 read clears rxf", flg_rxf, 0);
    chk("R5 hold released", scl_hold, 0);
    ev_rx_lastbit = 1; cyc();
    chk("R5 no hold when empty", scl_hold, 0);
  endtask

  task automatic t_slave();
    ctl_slave = 1;
    rx(1, {7'h2A, 1'b0});
    chk("R7 own address match", flg_match, 1);
    chk("R7 direction write", flg_read, 0);
    chk("R6 address byte no rxf", flg_rxf, 0);
    rx(0, 8'h11);
    chk("R6 data after match sets rxf", flg_rxf, 1);
    dr_rd = 1; sr_rd = 1; cyc();
    chk("R9 status read clears match", flg_match, 0);
    rx(1, {7'h2A, 1'b1});
    chk("R7 direction read", flg_read, 1);
    sr_rd = 1; cyc();
    chk("R9 direction held", flg_read, 1);
    rx(1, {7'h15, 1'b0});
    chk("R7 other address no match", flg_match, 0);
    rx(0, 8'h22);
    chk("R6 data after mismatch no rxf", flg_rxf, 0);
    chk("R10 irq idle", irq, 0);
    rx(1, 8'h00);
    chk("R8 general call off", flg_match, 0);
    ctl_gc_en = 1;
    rx(1, 8'h00);
    chk("R8 general call match", flg_match, 1);
    chk("R8 general call write", flg_read, 0);
    sr_rd = 1; cyc();
    rx(1, 8'h01);
    chk("R8 start byte match", flg_match, 1);
    chk("R8 start byte read", flg_read, 1);
    sr_rd = 1; cyc();
    ctl_gc_en = 0;
    ctl_interactive = 1;
    rx(1, {7'h15, 1'b0});
    chk("R6 interactive address sets rxf", flg_rxf, 1);
    chk("R6 interactive still no match", flg_match, 0);
    dr_rd = 1; cyc();
    rx(0, 8'h33);
    chk("R6 interactive data sets rxf", flg_rxf, 1);
  endtask

  task automatic t_irq();
    chk("R10 irq from rxf", irq, 1);
    ctl_enable = 0; brg_tick = 0;
    @(negedge clk);
    chk("R10 flags ignored when off", irq, 0);
    brg_tick = 1;
    @(negedge clk);
    chk("R10 timer tick drives irq", irq, 1);
    brg_tick = 0; ctl_enable = 1;
    @(negedge clk);
    chk("R10 back to flags", irq, 1);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    t_reset();
    t_txe();
    t_master_rx();
    t_slave();
    t_irq();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule